// File: doc/BRIEF.md
# Reflow Profile PWM Sequencer

This block runs an open-loop solder-reflow heating profile. A single push-button starts it. The sequencer then drives a heater-enable output with a slow pulse-width modulation. The profile has three timed phases, and each phase has a fixed, higher duty cycle than the one before: 30 %, then 40 %, then 60 %. After the third phase the output is switched off and the block returns to idle by itself. If the same button is pressed while a run is in progress, the run is aborted at once and the heater is forced off.

The button input is first synchronised and then filtered, so that only a clean, settled press acts on the sequencer. The PWM period is given in clock cycles, and each phase length is given as a whole number of PWM periods. As a result, every duty change falls on a period boundary. At the default settings the clock is 50 MHz and the PWM period is 2 s, which gives phases of 90 s, 90 s and 50 s. A simulation can shrink all of these timings through the parameters.

Top module: `reflow_pwm_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `heater_o`, `busy_o` and `phase_o` are all 0.
- R2: A filtered press while idle starts a run. `busy_o` stays 1 for every cycle of the run and is 0 at all other times.
- R3: `phase_o` reads 0 when idle. During a run it reads 1 for the first `SOAK_PERIODS` PWM periods, then 2 for `RAMP_PERIODS` periods, then 3 for `PEAK_PERIODS` periods.
- R4: Take k as the cycle count since the run began, with k = 0 in the first busy cycle. `heater_o` is 1 exactly when (k mod `PWM_PERIOD_CYC`) < (`PWM_PERIOD_CYC`/10)·d, where d is 3, 4 or 6 for phase 1, 2 or 3.
- R5: The on-time of the PWM changes only at the start of a PWM period, so no period mixes two duty values.
- R6: A filtered press during a run makes `busy_o`, `heater_o` and `phase_o` all 0 in the very next cycle.
- R7: When the run ends naturally, `busy_o` and `phase_o` return to 0 after exactly (`SOAK_PERIODS`+`RAMP_PERIODS`+`PEAK_PERIODS`)·`PWM_PERIOD_CYC` cycles.
- R8: `heater_o` is never 1 while the block is idle.
- R9: A button pulse that stays high on fewer than `DEBOUNCE_CYC` consecutive clock edges is ignored. Releasing the button never acts on the sequencer. Only the settled transition from 0 to 1 is a press.
- R10: `busy_o` first reads 1 (for a start) or 0 (for a cancel) right after the (`DEBOUNCE_CYC`+3)-th rising clock edge that samples `btn_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Raw push-button, asynchronous, active high |
| heater_o | output | 1 | Heater enable (PWM) |
| busy_o | output | 1 | High during a run |
| phase_o | output | 2 | 0 idle, 1 first phase, 2 second phase, 3 third phase |

## Verification
A wrong phase or period count shows at the ports at once: the phase code or the heater pulse edge moves by whole periods, and this becomes visible within one PWM period of the error. A stale on-time shows as a pulse of the wrong width in the first period after a phase change. A fault in the button filter moves the start or cancel edge away from its exact latency, or lets a short glitch start a run. The bench therefore compares every cycle of each run, including cancels placed on phase boundaries, against a cycle-count model.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOAK = 2'd1,
        PH_RAMP = 2'd2,
        PH_PEAK = 2'd3
    } phase_e;

    // Phase that follows p in the profile; the last one falls back to idle.
    function automatic phase_e phase_succ(phase_e p);
        case (p)
            PH_IDLE: return PH_SOAK;
            PH_SOAK: return PH_RAMP;
            PH_RAMP: return PH_PEAK;
            default: return PH_IDLE;
        endcase
    endfunction

    // Duty cycle in tenths of a PWM period for each phase.
    function automatic int unsigned duty_tenths(phase_e p);
        case (p)
            PH_SOAK: return 3;
            PH_RAMP: return 4;
            PH_PEAK: return 6;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rfl_btn_filter.sv
module rfl_btn_filter #(
    parameter int unsigned DEBOUNCE_CYC = 500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_o
);
    localparam int unsigned DW = $clog2(DEBOUNCE_CYC + 1);
    localparam logic [DW-1:0] DB_LAST = DW'(DEBOUNCE_CYC - 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic [DW-1:0] dcnt_q;
    logic          differs;

    assign differs = (sync_q[1] != level_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            level_q <= 1'b0;
            dcnt_q  <= '0;
            press_o <= 1'b0;
        end else begin
            sync_q  <= {sync_q[0], btn_raw};
            press_o <= 1'b0;
            if (!differs) begin
                dcnt_q <= '0;
            end else if (dcnt_q == DB_LAST) begin
                level_q <= sync_q[1];
                dcnt_q  <= '0;
                press_o <= sync_q[1];
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    // R9: a press is a single-cycle event
    assert_press_single_R9: assert property (@(posedge clk) disable iff (rst)
        press_o |=> !press_o);

    // R9: the filtered level only moves after a full settle window
    assert_level_settled_R9: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(dcnt_q) == DB_LAST && $past(differs)));

endmodule

// File: rtl/rfl_pwm_core.sv
module rfl_pwm_core #(
    parameter int unsigned PERIOD_CYC = 100_000_000,
    parameter int unsigned CW         = $clog2(PERIOD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] on_load,
    output logic          wrap_o,
    output logic          heater_o
);
    localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] on_q;

    assign wrap_o   = run && (cnt_q == CNT_LAST);
    assign heater_o = run && (cnt_q < on_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            on_q  <= '0;
        end else if (!run || wrap_o) begin
            cnt_q <= '0;
            on_q  <= on_load;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: on-time is frozen inside a period
    assert_duty_held_R5: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && cnt_q != '0) |-> $stable(on_q));

    // R4: period counter stays within the period
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);

    // R2: a run always begins at the start of a period
    assert_run_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/rfl_phase_ctrl.sv
module rfl_phase_ctrl
    import rfl_pkg::*;
#(
    parameter int unsigned PERIOD_CYC   = 100_000_000,
    parameter int unsigned CW           = $clog2(PERIOD_CYC + 1),
    parameter int unsigned SOAK_PERIODS = 45,
    parameter int unsigned RAMP_PERIODS = 45,
    parameter int unsigned PEAK_PERIODS = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          press,
    input  logic          wrap,
    output phase_e        phase_o,
    output logic [CW-1:0] on_load_o
);
    localparam int unsigned NMAX0 = (SOAK_PERIODS > RAMP_PERIODS) ? SOAK_PERIODS : RAMP_PERIODS;
    localparam int unsigned NMAX  = (NMAX0 > PEAK_PERIODS) ? NMAX0 : PEAK_PERIODS;
    localparam int unsigned PCW   = $clog2(NMAX + 1);
    localparam int unsigned SLICE = PERIOD_CYC / 10;

    function automatic logic [PCW-1:0] plen(phase_e p);
        case (p)
            PH_SOAK: return PCW'(SOAK_PERIODS);
            PH_RAMP: return PCW'(RAMP_PERIODS);
            PH_PEAK: return PCW'(PEAK_PERIODS);
            default: return PCW'(1);
        endcase
    endfunction

    phase_e         phase_q;
    logic [PCW-1:0] pcnt_q;
    logic           last_period;
    phase_e         phase_after;

    assign last_period = (pcnt_q == plen(phase_q) - PCW'(1));

    // Phase that governs the next PWM period; selects the on-time to load.
    always_comb begin
        if (phase_q == PH_IDLE)
            phase_after = PH_SOAK;
        else if (last_period)
            phase_after = phase_succ(phase_q);
        else
            phase_after = phase_q;
    end

    assign on_load_o = CW'(duty_tenths(phase_after) * SLICE);
    assign phase_o   = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pcnt_q  <= '0;
        end else if (press) begin
            phase_q <= (phase_q == PH_IDLE) ? PH_SOAK : PH_IDLE;
            pcnt_q  <= '0;
        end else if (phase_q != PH_IDLE && wrap) begin
            if (last_period) begin
                phase_q <= phase_succ(phase_q);
                pcnt_q  <= '0;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // R2: a press while idle enters the first phase
    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(press) && $past(phase_q) == PH_IDLE) |-> (phase_q == PH_SOAK));

    // R6: a press during a run returns to idle at once
    assert_cancel_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(press) && $past(phase_q) != PH_IDLE) |-> (phase_q == PH_IDLE));

    // R3: phases are only ever entered in profile order
    assert_order_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q) && phase_q != PH_IDLE) |-> (phase_q == phase_succ($past(phase_q))));

    // R7: end of the final period of the last phase shuts the run off
    assert_auto_off_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PEAK && wrap && last_period && !press) |=> (phase_q == PH_IDLE));

    // R3: period count bounded by the phase length
    assert_pcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> (pcnt_q < plen(phase_q)));

endmodule

// File: rtl/reflow_pwm_seq.sv
module reflow_pwm_seq
    import rfl_pkg::*;
#(
    parameter int unsigned PWM_PERIOD_CYC = 100_000_000,
    parameter int unsigned SOAK_PERIODS   = 45,
    parameter int unsigned RAMP_PERIODS   = 45,
    parameter int unsigned PEAK_PERIODS   = 25,
    parameter int unsigned DEBOUNCE_CYC   = 500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_i,
    output logic       heater_o,
    output logic       busy_o,
    output logic [1:0] phase_o
);
    localparam int unsigned CW = $clog2(PWM_PERIOD_CYC + 1);

    logic          press;
    logic          wrap;
    logic          run;
    logic [CW-1:0] on_load;
    phase_e        phase;

    rfl_btn_filter #(
        .DEBOUNCE_CYC(DEBOUNCE_CYC)
    ) u_btn (
        .clk    (clk),
        .rst    (rst),
        .btn_raw(btn_i),
        .press_o(press)
    );

    rfl_phase_ctrl #(
        .PERIOD_CYC  (PWM_PERIOD_CYC),
        .CW          (CW),
        .SOAK_PERIODS(SOAK_PERIODS),
        .RAMP_PERIODS(RAMP_PERIODS),
        .PEAK_PERIODS(PEAK_PERIODS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .press    (press),
        .wrap     (wrap),
        .phase_o  (phase),
        .on_load_o(on_load)
    );

    assign run = (phase != PH_IDLE);

    rfl_pwm_core #(
        .PERIOD_CYC(PWM_PERIOD_CYC),
        .CW        (CW)
    ) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .on_load (on_load),
        .wrap_o  (wrap),
        .heater_o(heater_o)
    );

    assign busy_o  = run;
    assign phase_o = phase;

    // R8: heater drive never outlives the run by a cycle
    assert_heater_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_o) && !busy_o) |-> !heater_o);

endmodule

// File: tb/reflow_pwm_seq_tb.sv
module reflow_pwm_seq_tb;
    localparam int P     = 20;
    localparam int N1    = 3;
    localparam int N2    = 3;
    localparam int N3    = 2;
    localparam int DB    = 4;
    localparam int LAT   = DB + 3;
    localparam int TOTAL = (N1 + N2 + N3) * P;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic       heater;
    logic       busy;
    logic [1:0] phase;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    reflow_pwm_seq #(
        .PWM_PERIOD_CYC(P),
        .SOAK_PERIODS  (N1),
        .RAMP_PERIODS  (N2),
        .PEAK_PERIODS  (N3),
        .DEBOUNCE_CYC  (DB)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .btn_i   (btn),
        .heater_o(heater),
        .busy_o  (busy),
        .phase_o (phase)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_phase(int k, int endk);
        int pi;
        if (k < 0 || k >= endk) return 0;
        pi = k / P;
        if (pi < N1) return 1;
        if (pi < N1 + N2) return 2;
        return 3;
    endfunction

    function automatic int exp_heater(int k, int endk);
        int ph;
        int tenths;
        ph = exp_phase(k, endk);
        if (ph == 0) return 0;
        tenths = (ph == 1) ? 3 : (ph == 2) ? 4 : 6;
        return ((k % P) < (P / 10) * tenths) ? 1 : 0;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One run started from idle; kc < 0 lets it finish, else cancel at k = kc.
    task automatic run_profile(int kc);
        int endk;
        endk = (kc < 0) ? TOTAL : kc + LAT;
        for (int j = 0; j <= LAT + endk + 12; j++) begin
            int k;
            string rq_b;
            string rq_h;
            @(negedge clk);
            k = j - LAT;
            if (k == -1 || k == 0) rq_b = "R10";
            else if (k >= endk) rq_b = (kc < 0) ? "R7" : "R6";
            else if (k >= 0) rq_b = "R2";
            else rq_b = "R2";
            if (k < 0 || k >= endk) rq_h = (kc >= 0 && k >= endk) ? "R6" : "R8";
            else if (k > 0 && (k % P) == 0) rq_h = "R5";
            else rq_h = "R4";
            check(rq_b, "busy", int'(busy), (exp_phase(k, endk) != 0) ? 1 : 0);
            check((k >= 0 && k < endk) ? "R3" : rq_b, "phase", int'(phase), exp_phase(k, endk));
            check(rq_h, "heater", int'(heater), exp_heater(k, endk));
            if (j == 0) btn = 1'b1;
            if (j == DB + 4) btn = 1'b0;
            if (kc >= 0 && k == kc) btn = 1'b1;
            if (kc >= 0 && k == kc + DB + 4) btn = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", "heater in reset", int'(heater), 0);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "phase in reset", int'(phase), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "heater after reset", int'(heater), 0);

        // R9: glitch one edge shorter than the settle window is ignored
        btn = 1'b1;
        repeat (DB - 1) @(negedge clk);
        btn = 1'b0;
        for (int i = 0; i < 3 * DB + 6; i++) begin
            @(negedge clk);
            check("R9", "busy after short glitch", int'(busy), 0);
            check("R9", "heater after short glitch", int'(heater), 0);
        end

        // Directed: full run, early cancel, cancel landing on a phase edge, late cancel
        run_profile(-1);
        run_profile(10);
        run_profile(N1 * P - LAT);
        run_profile(TOTAL - LAT - 3);

        // Random mix of completed and cancelled runs
        for (int r = 0; r < 6; r++) begin
            int kc;
            kc = ($urandom % 3 == 0) ? -1 : 10 + int'($urandom % 141);
            run_profile(kc);
        end

        report();
        $finish;
    end
endmodule